// File: doc/BRIEF.md
# Overlapped Translation and Cache Lookup Unit

This block serves loads for a cache that is indexed with virtual address bits and tagged with physical page numbers. On each request it splits the virtual address into two parts. The page displacement goes straight to a direct-mapped line array. At the same time, the virtual page number is searched in a small fully associative translation buffer. Only displacement bits index the array, so neither lookup has to wait for the other. The translated physical page number is then compared with the stored line tag. One cycle after the request, a registered result reports exactly one of three outcomes: the data is delivered, a memory access is needed at the translated physical address, or the translation is missing and must be resolved elsewhere.

Translation entries are written through a slot-addressed load port, and a flush strobe clears them all. Cache lines are written through a separate fill port that supplies an index, a tag and a data word. Requests use a single valid strobe and carry no back-pressure. The unit accepts a request in every cycle where `req_valid` is high and returns its result in the next cycle. Any consumer must therefore take each result in the cycle it appears.

Top module: `overlap_lookup`

## Requirements
- R1: After reset, `rsp_valid`, all three outcome flags, `rsp_paddr` and `rsp_data` are 0, and every translation slot and cache line is invalid. A lookup made before any load reports a translation miss.
- R2: A request sampled at a clock edge produces its result, with `rsp_valid` high, in the following cycle. Back-to-back requests give back-to-back results. A cycle with no request gives `rsp_valid` low and all outputs 0 in the next cycle.
- R3: Whenever `rsp_valid` is high, exactly one of `rsp_hit`, `rsp_mem_req` and `rsp_xlate_miss` is high.
- R4: If the page number matches a valid slot, and the line at index `vaddr[11:2]` is valid with a tag equal to that slot's physical page number, then `rsp_hit` is 1 and `rsp_data` is the line's data.
- R5: If the page number matches a valid slot but the indexed line is invalid or holds a different tag, then `rsp_mem_req` is 1, `rsp_paddr` is {physical page, `vaddr[11:0]`}, and `rsp_data` is 0.
- R6: If no valid slot matches `vaddr[31:12]`, then `rsp_xlate_miss` is 1 and `rsp_paddr` and `rsp_data` are 0.
- R7: The line index is `vaddr[11:2]` and the byte offset `vaddr[1:0]` is not used in the line choice. Two virtual pages that translate to the same physical page therefore hit the same line. On any translated result, `rsp_paddr[11:0]` equals `vaddr[11:0]`.
- R8: When several valid slots hold the same virtual page number, the slot with the lowest index supplies the translation.
- R9: `tlb_flush` invalidates every slot. A load in the same cycle as a flush still leaves its own slot valid with the loaded contents.
- R10: A load writes its slot's page numbers and sets the slot valid, replacing any earlier contents. A lookup in the same cycle as a load or fill sees the contents from before that write.
- R11: A fill sets the indexed line valid and replaces its tag and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | VA_W (32) | Virtual address of the request |
| tlb_we | input | 1 | Translation slot load strobe |
| tlb_slot | input | log2(TLB_SLOTS) (5) | Slot to load |
| tlb_vpn | input | VA_W-PAGE_BITS (20) | Virtual page number to load |
| tlb_ppn | input | PA_W-PAGE_BITS (20) | Physical page number to load |
| tlb_flush | input | 1 | Invalidate all translation slots |
| fill_we | input | 1 | Cache line fill strobe |
| fill_idx | input | PAGE_BITS-BYTE_BITS (10) | Line index to fill |
| fill_tag | input | PA_W-PAGE_BITS (20) | Physical page tag for the line |
| fill_data | input | DATA_W (32) | Line data word |
| rsp_valid | output | 1 | A result is present this cycle |
| rsp_hit | output | 1 | Cache hit, data valid |
| rsp_data | output | DATA_W (32) | Data delivered on a hit, else 0 |
| rsp_paddr | output | PA_W (32) | Translated physical address, 0 on translation miss |
| rsp_mem_req | output | 1 | Memory access needed at `rsp_paddr` |
| rsp_xlate_miss | output | 1 | No translation present |

## Verification
The bench builds the unit with its defaults: 4 KB pages, a 4 KB direct-mapped array of 1024 four-byte lines, and 32 translation slots. With these values the full index is 10 bits of the displacement, so synonyms from different virtual pages can be aimed at one line. Duplicate page numbers can be placed in non-adjacent slots such as 5 and 9 to show the priority rule. A line can also be made stale by reloading a slot with a new physical page. The default sizes likewise place same-cycle load, fill and flush collisions next to live lookups.

// File: rtl/olk_pkg.sv
package olk_pkg;

  // Outcome of one lookup; exactly one applies per accepted request.
  typedef enum logic [1:0] {
    KIND_HIT   = 2'd0,
    KIND_MEM   = 2'd1,
    KIND_XMISS = 2'd2
  } lookup_kind_e;

endpackage

// File: rtl/olk_tlb.sv
// Fully associative translation buffer: parallel compare, lowest slot wins.
module olk_tlb #(
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int SLOTS  = 32,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             flush
);

  logic [SLOTS-1:0] ent_vld;
  logic [VPN_W-1:0] ent_vpn [SLOTS];
  logic [PPN_W-1:0] ent_ppn [SLOTS];
  logic [SLOTS-1:0] match;
  logic [SLOTS-1:0] grant;

  // Valid bits: a flush clears everything, a load in the same cycle wins for its slot.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld <= '0;
    end else begin
      if (flush) ent_vld <= '0;
      if (wr_en) ent_vld[wr_slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_vpn[wr_slot] <= wr_vpn;
      ent_ppn[wr_slot] <= wr_ppn;
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    assign match[g] = ent_vld[g] && (ent_vpn[g] == lk_vpn);
  end

  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (match[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    lk_ppn = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (grant[i]) lk_ppn = lk_ppn | ent_ppn[i];
    end
  end

  assign lk_hit = |match;

  AST_GRANT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (lk_hit == (grant != '0))); // R8

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !wr_en) |=> (ent_vld == '0)); // R9

  AST_LOAD_SETS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ent_vld[$past(wr_slot)]); // R10

endmodule

// File: rtl/olk_dm_array.sv
// Direct-mapped line store with an asynchronous read and a fill write port.
module olk_dm_array #(
  parameter int IDX_W  = 10,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 32,
  localparam int LINES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_vld,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);

  logic [LINES-1:0]  line_vld;
  logic [TAG_W-1:0]  line_tag  [LINES];
  logic [DATA_W-1:0] line_data [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_vld <= '0;
    end else if (wr_en) begin
      line_vld[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      line_tag[wr_idx]  <= wr_tag;
      line_data[wr_idx] <= wr_data;
    end
  end

  assign rd_vld  = line_vld[rd_idx];
  assign rd_tag  = line_tag[rd_idx];
  assign rd_data = line_data[rd_idx];

  AST_FILL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> line_vld[$past(wr_idx)]); // R11

endmodule

// File: rtl/olk_outcome.sv
// Physical tag compare and three-way outcome decision.
module olk_outcome
  import olk_pkg::*;
#(
  parameter int PPN_W     = 20,
  parameter int PAGE_BITS = 12,
  parameter int DATA_W    = 32,
  localparam int PA_W     = PPN_W + PAGE_BITS
) (
  input  logic                 tlb_hit,
  input  logic [PPN_W-1:0]     tlb_ppn,
  input  logic                 line_vld,
  input  logic [PPN_W-1:0]     line_tag,
  input  logic [DATA_W-1:0]    line_data,
  input  logic [PAGE_BITS-1:0] disp,
  output lookup_kind_e         kind,
  output logic [PA_W-1:0]      paddr,
  output logic [DATA_W-1:0]    data
);

  logic tag_eq;
  assign tag_eq = line_vld && (line_tag == tlb_ppn);

  always_comb begin
    kind  = KIND_XMISS;
    paddr = '0;
    data  = '0;
    if (tlb_hit) begin
      paddr = {tlb_ppn, disp};
      if (tag_eq) begin
        kind = KIND_HIT;
        data = line_data;
      end else begin
        kind = KIND_MEM;
      end
    end
  end

endmodule

// File: rtl/overlap_lookup.sv
// Top: translation and line read in parallel, result registered one cycle later.
module overlap_lookup
  import olk_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int BYTE_BITS = 2,
  parameter int TLB_SLOTS = 32,
  parameter int DATA_W    = 32,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PPN_W    = PA_W - PAGE_BITS,
  localparam int IDX_W    = PAGE_BITS - BYTE_BITS,
  localparam int SLOT_W   = (TLB_SLOTS > 1) ? $clog2(TLB_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              tlb_we,
  input  logic [SLOT_W-1:0] tlb_slot,
  input  logic [VPN_W-1:0]  tlb_vpn,
  input  logic [PPN_W-1:0]  tlb_ppn,
  input  logic              tlb_flush,
  input  logic              fill_we,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [PPN_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_mem_req,
  output logic              rsp_xlate_miss
);

  // Address split: index and offset come only from the displacement.
  logic [VPN_W-1:0]     va_vpn;
  logic [PAGE_BITS-1:0] va_disp;
  logic [IDX_W-1:0]     va_idx;
  assign va_vpn  = req_vaddr[VA_W-1:PAGE_BITS];
  assign va_disp = req_vaddr[PAGE_BITS-1:0];
  assign va_idx  = req_vaddr[PAGE_BITS-1:BYTE_BITS];

  logic              xl_hit;
  logic [PPN_W-1:0]  xl_ppn;
  logic              ln_vld;
  logic [PPN_W-1:0]  ln_tag;
  logic [DATA_W-1:0] ln_data;

  olk_tlb #(.VPN_W(VPN_W), .PPN_W(PPN_W), .SLOTS(TLB_SLOTS)) u_tlb (
    .clk    (clk),
    .rst_n  (rst_n),
    .lk_vpn (va_vpn),
    .lk_hit (xl_hit),
    .lk_ppn (xl_ppn),
    .wr_en  (tlb_we),
    .wr_slot(tlb_slot),
    .wr_vpn (tlb_vpn),
    .wr_ppn (tlb_ppn),
    .flush  (tlb_flush)
  );

  olk_dm_array #(.IDX_W(IDX_W), .TAG_W(PPN_W), .DATA_W(DATA_W)) u_lines (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (va_idx),
    .rd_vld (ln_vld),
    .rd_tag (ln_tag),
    .rd_data(ln_data),
    .wr_en  (fill_we),
    .wr_idx (fill_idx),
    .wr_tag (fill_tag),
    .wr_data(fill_data)
  );

  lookup_kind_e      dec_kind;
  logic [PA_W-1:0]   dec_paddr;
  logic [DATA_W-1:0] dec_data;

  olk_outcome #(.PPN_W(PPN_W), .PAGE_BITS(PAGE_BITS), .DATA_W(DATA_W)) u_decide (
    .tlb_hit  (xl_hit),
    .tlb_ppn  (xl_ppn),
    .line_vld (ln_vld),
    .line_tag (ln_tag),
    .line_data(ln_data),
    .disp     (va_disp),
    .kind     (dec_kind),
    .paddr    (dec_paddr),
    .data     (dec_data)
  );

  logic              vld_q;
  lookup_kind_e      kind_q;
  logic [PA_W-1:0]   paddr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      kind_q  <= KIND_XMISS;
      paddr_q <= '0;
      data_q  <= '0;
    end else if (req_valid) begin
      vld_q   <= 1'b1;
      kind_q  <= dec_kind;
      paddr_q <= dec_paddr;
      data_q  <= dec_data;
    end else begin
      vld_q   <= 1'b0;
      kind_q  <= KIND_XMISS;
      paddr_q <= '0;
      data_q  <= '0;
    end
  end

  assign rsp_valid      = vld_q;
  assign rsp_hit        = vld_q && (kind_q == KIND_HIT);
  assign rsp_mem_req    = vld_q && (kind_q == KIND_MEM);
  assign rsp_xlate_miss = vld_q && (kind_q == KIND_XMISS);
  assign rsp_paddr      = paddr_q;
  assign rsp_data       = data_q;

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_hit, rsp_mem_req, rsp_xlate_miss})); // R3

  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_mem_req && !rsp_xlate_miss)); // R2

  AST_DISP_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && xl_hit) |=> (rsp_paddr[PAGE_BITS-1:0] == $past(va_disp))); // R7

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_xlate_miss |-> (rsp_paddr == '0 && rsp_data == '0)); // R6

  AST_DATA_ONLY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_mem_req |-> (rsp_data == '0)); // R5

endmodule

// File: tb/overlap_lookup_tb.sv
module overlap_lookup_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  // Outcome codes used by the vector table: 0 hit, 1 memory access, 2 translation miss.
  localparam logic [31:0] T_VA [NVEC] = '{
    32'h1234_5043, 32'h0000_1040, 32'h0000_20C0,
    32'h0000_2080, 32'h0000_3084, 32'h5432_1000};
  localparam int T_KIND [NVEC] = '{0, 0, 1, 1, 0, 2};
  localparam logic [31:0] T_PA [NVEC] = '{
    32'h00AB_C043, 32'h00AB_C040, 32'h7777_70C0,
    32'h7777_7080, 32'h1111_1084, 32'h0000_0000};
  localparam logic [31:0] T_DATA [NVEC] = '{
    32'hCAFE_0001, 32'hCAFE_0001, 32'h0, 32'h0, 32'hBEEF_0021, 32'h0};
  localparam string T_REQ [NVEC] = '{"R4", "R7", "R5", "R5", "R8", "R6"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        tlb_we = 1'b0;
  logic [4:0]  tlb_slot = '0;
  logic [19:0] tlb_vpn = '0;
  logic [19:0] tlb_ppn = '0;
  logic        tlb_flush = 1'b0;
  logic        fill_we = 1'b0;
  logic [9:0]  fill_idx = '0;
  logic [19:0] fill_tag = '0;
  logic [31:0] fill_data = '0;
  logic        rsp_valid, rsp_hit, rsp_mem_req, rsp_xlate_miss;
  logic [31:0] rsp_data, rsp_paddr;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  overlap_lookup u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .tlb_we(tlb_we), .tlb_slot(tlb_slot), .tlb_vpn(tlb_vpn), .tlb_ppn(tlb_ppn),
    .tlb_flush(tlb_flush), .fill_we(fill_we), .fill_idx(fill_idx),
    .fill_tag(fill_tag), .fill_data(fill_data), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_data(rsp_data), .rsp_paddr(rsp_paddr),
    .rsp_mem_req(rsp_mem_req), .rsp_xlate_miss(rsp_xlate_miss));

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] flags_for(input int kind);
    return {28'd0, 1'b1, kind == 0, kind == 1, kind == 2};
  endfunction

  function automatic logic [31:0] flags_now();
    return {28'd0, rsp_valid, rsp_hit, rsp_mem_req, rsp_xlate_miss};
  endfunction

  // Checks the result present now against the expectation.
  task automatic check_rsp(input string req, input int kind, input logic [31:0] pa,
                           input logic [31:0] data);
    chk(req, "flags{valid,hit,mem,xmiss}", flags_now(), flags_for(kind));
    chk(req, "paddr", rsp_paddr, pa);
    chk(req, "data", rsp_data, data);
  endtask

  task automatic lookup(input logic [31:0] va, input int kind, input logic [31:0] pa,
                        input logic [31:0] data, input string req);
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(req, kind, pa, data);
  endtask

  task automatic load(input int slot, input logic [19:0] vpn, input logic [19:0] ppn);
    @(negedge clk);
    tlb_we = 1'b1; tlb_slot = 5'(slot); tlb_vpn = vpn; tlb_ppn = ppn;
    @(negedge clk);
    tlb_we = 1'b0;
  endtask

  task automatic fill(input logic [9:0] idx, input logic [19:0] tag, input logic [31:0] d);
    @(negedge clk);
    fill_we = 1'b1; fill_idx = idx; fill_tag = tag; fill_data = d;
    @(negedge clk);
    fill_we = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R2 watchdog: actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the outputs
    chk("R1", "flags after reset", flags_now(), 32'h0);
    chk("R1", "paddr after reset", rsp_paddr, 32'h0);
    chk("R1", "data after reset", rsp_data, 32'h0);
    // R1: empty translation buffer gives a translation miss
    lookup(32'h1234_5043, 2, 32'h0, 32'h0, "R1");

    // Setup for the vector table
    load(0, 20'h12345, 20'h00ABC);
    load(1, 20'h00001, 20'h00ABC);
    load(2, 20'h00002, 20'h77777);
    load(5, 20'h00003, 20'h11111);
    load(9, 20'h00003, 20'h22222);
    fill(10'h010, 20'h00ABC, 32'hCAFE_0001);
    fill(10'h030, 20'h99999, 32'h1234_5678);
    fill(10'h021, 20'h11111, 32'hBEEF_0021);

    for (int i = 0; i < NVEC; i++) begin
      lookup(T_VA[i], T_KIND[i], T_PA[i], T_DATA[i], T_REQ[i]);
    end

    // R2: back-to-back requests, then an idle cycle
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h1234_5043;
    @(negedge clk);
    check_rsp("R2", 0, 32'h00AB_C043, 32'hCAFE_0001);
    req_vaddr = 32'h5432_1000;
    @(negedge clk);
    check_rsp("R2", 2, 32'h0, 32'h0);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R2", "flags idle", flags_now(), 32'h0);
    chk("R2", "paddr idle", rsp_paddr, 32'h0);

    // R10: lookup in the same cycle as a load sees the old contents
    @(negedge clk);
    tlb_we = 1'b1; tlb_slot = 5'd3; tlb_vpn = 20'h00004; tlb_ppn = 20'h44444;
    req_valid = 1'b1; req_vaddr = 32'h0000_4000;
    @(negedge clk);
    tlb_we = 1'b0; req_valid = 1'b0;
    check_rsp("R10", 2, 32'h0, 32'h0);
    lookup(32'h0000_4000, 1, 32'h4444_4000, 32'h0, "R10");

    // R10: lookup in the same cycle as a fill sees the old line
    @(negedge clk);
    fill_we = 1'b1; fill_idx = 10'h000; fill_tag = 20'h44444; fill_data = 32'h0A0A_0A0A;
    req_valid = 1'b1; req_vaddr = 32'h0000_4000;
    @(negedge clk);
    fill_we = 1'b0; req_valid = 1'b0;
    check_rsp("R10", 1, 32'h4444_4000, 32'h0);
    lookup(32'h0000_4000, 0, 32'h4444_4000, 32'h0A0A_0A0A, "R11");

    // R10: reloading a slot replaces its translation, leaving the line stale
    load(0, 20'h12345, 20'h55555);
    lookup(32'h1234_5043, 1, 32'h5555_5043, 32'h0, "R10");

    // R11: a fill replaces tag and data
    fill(10'h010, 20'h55555, 32'hD00D_0010);
    lookup(32'h1234_5043, 0, 32'h5555_5043, 32'hD00D_0010, "R11");
    lookup(32'h0000_1040, 1, 32'h00AB_C040, 32'h0, "R11");

    // R9: flush together with a load
    @(negedge clk);
    tlb_flush = 1'b1;
    tlb_we = 1'b1; tlb_slot = 5'd7; tlb_vpn = 20'h00006; tlb_ppn = 20'h66666;
    @(negedge clk);
    tlb_flush = 1'b0; tlb_we = 1'b0;
    lookup(32'h0000_2000, 2, 32'h0, 32'h0, "R9");
    lookup(32'h0000_4000, 2, 32'h0, 32'h0, "R9");
    lookup(32'h0000_6000, 1, 32'h6666_6000, 32'h0, "R9");

    // R3: every result seen above was one-hot; check one more translated hit offset
    lookup(32'h0000_6003, 1, 32'h6666_6003, 32'h0, "R3");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule